// File: doc/BRIEF.md
# Multi-task pause and release unit

This unit lives in the sequencer of a small core that interleaves four hardware tasks. Each task owns one clock cycle in a fixed rotation. The unit keeps the program counter of every task. It also carries out a combined "post a request, then wait" instruction. On the task's first slot, the instruction stores a 9-bit request code into a chosen register and freezes the task's program counter. On each later slot of that task, the unit reads the same register again. The task stays frozen until the register shows the release pattern. Any other task can then let it go by writing that shared register.

There are two wait flavours. In the default flavour, the task waits for the whole register to read zero. In the flag flavour, the two low code bits pick one of the top four register bits as a private busy flag. The other bits stay free to carry data in either direction, and one master write can free several waiters at once.

A separate resume command port can also free a paused task, from outside the polling loop. It can either step the program counter past the wait or leave it where it is. Either way it can arm a single step, after which the task parks itself again. This lets a debugger restore an overwritten instruction, run it once, and then re-plant the breakpoint.

Top module: `tpu_pause_unit`

## Requirements
- R1: After reset, every program counter is 0, every paused flag is 0 and the active slot is task 0. The slot then advances by one task per clock, 0,1,2,3,0,...
- R2: When a running task issues the pause instruction in its slot, the unit writes the 9-bit code to the destination register in that same clock. In the default flavour the code is zero-extended. The task's paused flag rises and its program counter keeps its value.
- R3: While a task is paused, its program counter does not change. Its slots produce no register write, and each of its slots reads the remembered destination register.
- R4: In the default flavour, a poll that reads an all-zero register releases the task, and its program counter becomes the pause address plus one.
- R5: A pause with code 0 in the default flavour releases itself on the task's next slot without outside help, with program counter plus one.
- R6: A register write by another agent on the same clock edge as a poll is not seen by that poll. The task stays paused and sees the new value on its following slot.
- R7: Flag flavour: code bits [1:0] select register bit 28 + code[1:0], so 3 selects bit 31. The pause write keeps the old register bits 31..9, sets the selected bit, and places the 9-bit code in bits 8..0.
- R8: Flag flavour: the task is released, with program counter plus one, when its selected bit reads zero, whatever bits 27..0 hold. One register write that clears several selected bits releases all of those waiters.
- R9: A resume command with its advance flag set releases a paused target with program counter plus one. With the flag clear, it releases the target and leaves the program counter unchanged.
- R10: A resume with the step flag lets the target run exactly one instruction, which advances its program counter normally, and then re-pauses it. This hold pause ignores register contents and ends only on a later resume.
- R11: A resume command that names a task which is not paused has no effect. In particular, it arms no single step.
- R12: If a poll release and a resume command hit the same task in the same clock, they act as one release, and the program counter advances by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_o | output | 2 | Task owning the current clock |
| fetch_pc_o | output | 16 | Program counter of the active task |
| pcs_o | output | 64 | All program counters, task i at bits [16i+15:16i] |
| op_pause_i | input | 1 | Current instruction is the pause instruction |
| op_flag_i | input | 1 | Pause uses the flag flavour |
| op_dst_i | input | 5 | Destination register of the pause |
| op_code_i | input | 9 | Request code of the pause |
| jump_en_i | input | 1 | Current non-pause instruction loads a new program counter |
| jump_pc_i | input | 16 | Target for jump_en_i |
| rf_re_o | output | 1 | Register read in use |
| rf_raddr_o | output | 5 | Register read address |
| rf_rdata_i | input | 32 | Register read data (combinational, pre-edge value) |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write address |
| rf_wdata_o | output | 32 | Register write data |
| rsm_valid_i | input | 1 | Resume command present |
| rsm_task_i | input | 2 | Resume target task |
| rsm_inc_i | input | 1 | Resume advances the program counter |
| rsm_step_i | input | 1 | Resume arms a single step |
| paused_o | output | 4 | Per-task paused flags |

## Verification
The assertions check several rules on every clock. The slot rotation must be correct. Any register write must be followed by the writer being paused, and no write may come from a paused slot. A paused task's program counter must stay frozen while it remains paused. Any release may advance the program counter by at most one, which covers the merged case. Other behaviours depend on register contents and on the order of several tasks' slots, so only the bench scenarios show them. These are the exact words written in both flavours, the old-value visibility of a poll, the single-step count and its hold pause, and the multi-waiter release from one write.

// File: rtl/tpu_pkg.sv
package tpu_pkg;

    // Wait state of one task; RUN means not paused.
    typedef enum logic [1:0] {
        WK_RUN  = 2'd0,
        WK_ZERO = 2'd1,
        WK_FLAG = 2'd2,
        WK_HOLD = 2'd3
    } wait_kind_e;

    typedef struct packed {
        logic valid;
        logic inc;
        logic step;
    } resume_cmd_t;

    // Number of flag bits at the top of the polled word.
    localparam int unsigned FLAG_N = 4;

    function automatic logic [FLAG_N-1:0] flag_onehot(input logic [1:0] sel);
        return FLAG_N'(1) << sel;
    endfunction

    function automatic logic is_polling(input wait_kind_e k);
        return (k == WK_ZERO) || (k == WK_FLAG);
    endfunction

    function automatic logic poll_pass(input wait_kind_e k, input logic word_zero,
                                       input logic [FLAG_N-1:0] flags,
                                       input logic [1:0] sel);
        case (k)
            WK_ZERO: return word_zero;
            WK_FLAG: return !flags[sel];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tpu_slot_ctr.sv
module tpu_slot_ctr #(
    parameter int unsigned N_TASK = 4,
    localparam int unsigned TW = (N_TASK > 1) ? $clog2(N_TASK) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [TW-1:0] slot
);
    localparam logic [TW-1:0] LAST = TW'(N_TASK - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (slot == LAST) begin
            slot <= '0;
        end else begin
            slot <= slot + TW'(1);
        end
    end
endmodule

// File: rtl/tpu_poll_eval.sv
module tpu_poll_eval
    import tpu_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  wait_kind_e    kind,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] rdata,
    output logic          release_ok
);
    logic            word_zero;
    logic [FLAG_N-1:0] flags;

    assign word_zero  = (rdata == '0);
    assign flags      = rdata[DW-1 -: FLAG_N];
    assign release_ok = poll_pass(kind, word_zero, flags, sel);
endmodule

// File: rtl/tpu_pause_word.sv
module tpu_pause_word
    import tpu_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned CODEW = 9
) (
    input  logic [CODEW-1:0] code,
    input  logic             flag_mode,
    input  logic [DW-1:0]    old_word,
    output logic [DW-1:0]    word
);
    always_comb begin
        if (flag_mode) begin
            // read-modify-write: keep other flags and the middle data bits
            word                  = old_word;
            word[DW-1 -: FLAG_N]  = old_word[DW-1 -: FLAG_N] | flag_onehot(code[1:0]);
            word[CODEW-1:0]       = code;
        end else begin
            word                  = '0;
            word[CODEW-1:0]       = code;
        end
    end
endmodule

// File: rtl/tpu_task_ctx.sv
module tpu_task_ctx
    import tpu_pkg::*;
#(
    parameter int unsigned PCW = 16,
    parameter int unsigned AW  = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           slot_hit,
    input  logic           poll_rel,
    input  logic           op_pause,
    input  logic           op_flag,
    input  logic [AW-1:0]  op_dst,
    input  logic [1:0]     op_sel,
    input  logic           jump_en,
    input  logic [PCW-1:0] jump_pc,
    input  resume_cmd_t    rsm,
    output logic [PCW-1:0] pc_o,
    output wait_kind_e     kind_o,
    output logic           armed_o,
    output logic [AW-1:0]  dst_o,
    output logic [1:0]     sel_o
);
    logic           self_release;
    logic           ext_release;
    logic [PCW-1:0] pc_step;
    logic [PCW-1:0] pc_exec;

    assign self_release = slot_hit && is_polling(kind_o) && poll_rel;
    // a resume only counts if the task is paused and did not free itself now
    assign ext_release  = rsm.valid && (kind_o != WK_RUN) && !self_release;
    assign pc_step      = pc_o + PCW'(1);
    assign pc_exec      = jump_en ? jump_pc : pc_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_o    <= '0;
            kind_o  <= WK_RUN;
            armed_o <= 1'b0;
            dst_o   <= '0;
            sel_o   <= '0;
        end else if (self_release) begin
            kind_o <= WK_RUN;
            pc_o   <= pc_step;
        end else if (ext_release) begin
            kind_o  <= WK_RUN;
            armed_o <= rsm.step;
            if (rsm.inc) begin
                pc_o <= pc_step;
            end
        end else if (slot_hit && kind_o == WK_RUN) begin
            if (armed_o) begin
                // the single stepped instruction, then park
                armed_o <= 1'b0;
                kind_o  <= WK_HOLD;
                pc_o    <= pc_exec;
            end else if (op_pause) begin
                kind_o <= op_flag ? WK_FLAG : WK_ZERO;
                dst_o  <= op_dst;
                sel_o  <= op_sel;
            end else begin
                pc_o <= pc_exec;
            end
        end
    end
endmodule

// File: rtl/tpu_pause_unit.sv
module tpu_pause_unit
    import tpu_pkg::*;
#(
    parameter int unsigned N_TASK = 4,
    parameter int unsigned PCW    = 16,
    parameter int unsigned DW     = 32,
    parameter int unsigned AW     = 5,
    parameter int unsigned CODEW  = 9,
    localparam int unsigned TW    = (N_TASK > 1) ? $clog2(N_TASK) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [TW-1:0]         slot_o,
    output logic [PCW-1:0]        fetch_pc_o,
    output logic [N_TASK*PCW-1:0] pcs_o,
    input  logic                  op_pause_i,
    input  logic                  op_flag_i,
    input  logic [AW-1:0]         op_dst_i,
    input  logic [CODEW-1:0]      op_code_i,
    input  logic                  jump_en_i,
    input  logic [PCW-1:0]        jump_pc_i,
    output logic                  rf_re_o,
    output logic [AW-1:0]         rf_raddr_o,
    input  logic [DW-1:0]         rf_rdata_i,
    output logic                  rf_we_o,
    output logic [AW-1:0]         rf_waddr_o,
    output logic [DW-1:0]         rf_wdata_o,
    input  logic                  rsm_valid_i,
    input  logic [TW-1:0]         rsm_task_i,
    input  logic                  rsm_inc_i,
    input  logic                  rsm_step_i,
    output logic [N_TASK-1:0]     paused_o
);
    logic [TW-1:0]  slot;
    logic [PCW-1:0] pc_q    [N_TASK];
    wait_kind_e     kind_q  [N_TASK];
    logic           armed_q [N_TASK];
    logic [AW-1:0]  dst_q   [N_TASK];
    logic [1:0]     sel_q   [N_TASK];

    wait_kind_e cur_kind;
    logic       cur_running;
    logic       cur_polling;
    logic       poll_rel;

    tpu_slot_ctr #(.N_TASK(N_TASK)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    assign cur_kind    = kind_q[slot];
    assign cur_polling = is_polling(cur_kind);
    assign cur_running = (cur_kind == WK_RUN) && !armed_q[slot];

    // register port: poll read while paused, old-word read for a flag pause
    assign rf_we_o    = cur_running && op_pause_i;
    assign rf_waddr_o = op_dst_i;
    assign rf_re_o    = cur_polling || (rf_we_o && op_flag_i);
    assign rf_raddr_o = cur_polling ? dst_q[slot] : op_dst_i;

    tpu_poll_eval #(.DW(DW)) u_poll (
        .kind       (cur_kind),
        .sel        (sel_q[slot]),
        .rdata      (rf_rdata_i),
        .release_ok (poll_rel)
    );

    tpu_pause_word #(.DW(DW), .CODEW(CODEW)) u_word (
        .code      (op_code_i),
        .flag_mode (op_flag_i),
        .old_word  (rf_rdata_i),
        .word      (rf_wdata_o)
    );

    for (genvar i = 0; i < N_TASK; i++) begin : g_task
        resume_cmd_t rsm;
        assign rsm.valid = rsm_valid_i && (rsm_task_i == TW'(i));
        assign rsm.inc   = rsm_inc_i;
        assign rsm.step  = rsm_step_i;

        tpu_task_ctx #(.PCW(PCW), .AW(AW)) u_ctx (
            .clk      (clk),
            .rst      (rst),
            .slot_hit (slot == TW'(i)),
            .poll_rel (poll_rel),
            .op_pause (op_pause_i),
            .op_flag  (op_flag_i),
            .op_dst   (op_dst_i),
            .op_sel   (op_code_i[1:0]),
            .jump_en  (jump_en_i),
            .jump_pc  (jump_pc_i),
            .rsm      (rsm),
            .pc_o     (pc_q[i]),
            .kind_o   (kind_q[i]),
            .armed_o  (armed_q[i]),
            .dst_o    (dst_q[i]),
            .sel_o    (sel_q[i])
        );

        assign pcs_o[i*PCW +: PCW] = pc_q[i];
        assign paused_o[i]         = (kind_q[i] != WK_RUN);
    end

    assign slot_o     = slot;
    assign fetch_pc_o = pc_q[slot];
endmodule

// File: rtl/tpu_pause_chk.sv
module tpu_pause_chk #(
    parameter int unsigned N_TASK = 4,
    parameter int unsigned PCW    = 16,
    localparam int unsigned TW    = (N_TASK > 1) ? $clog2(N_TASK) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [TW-1:0]         slot_o,
    input logic [N_TASK-1:0]     paused_o,
    input logic [N_TASK*PCW-1:0] pcs_o,
    input logic                  rf_we_o,
    input logic                  rf_re_o
);
    localparam logic [TW-1:0] LAST = TW'(N_TASK - 1);

    // R1: strict rotation of slots
    p_slot_rotation_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> slot_o == (($past(slot_o) == LAST) ? '0 : $past(slot_o) + TW'(1)));

    // R2: a pause write always leaves its issuer paused
    p_write_then_paused_r2: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |=> paused_o[$past(slot_o)]);

    // R3: no write comes from a paused slot
    p_no_write_when_paused_r3: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> !paused_o[slot_o]);

    // R3: a read that is not part of a pause write is a poll of a paused task
    p_read_is_poll_r3: assert property (@(posedge clk) disable iff (rst)
        (rf_re_o && !rf_we_o) |-> paused_o[slot_o]);

    for (genvar t = 0; t < N_TASK; t++) begin : g_chk
        // R3: frozen program counter while staying paused
        p_pc_frozen_r3: assert property (@(posedge clk) disable iff (rst)
            (paused_o[t] && $past(paused_o[t])) |-> $stable(pcs_o[t*PCW +: PCW]));

        // R12: any release advances by at most one
        p_release_once_r12: assert property (@(posedge clk) disable iff (rst)
            $fell(paused_o[t]) |->
                ((pcs_o[t*PCW +: PCW] == $past(pcs_o[t*PCW +: PCW])) ||
                 (pcs_o[t*PCW +: PCW] == $past(pcs_o[t*PCW +: PCW]) + PCW'(1))));
    end
endmodule

bind tpu_pause_unit tpu_pause_chk #(.N_TASK(N_TASK), .PCW(PCW)) u_chk (.*);

// File: tb/sim_tpu_pause_unit.sv
module sim_tpu_pause_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  slot_o;
    logic [15:0] fetch_pc_o;
    logic [63:0] pcs_o;
    logic        op_pause, op_flag, jump_en;
    logic [4:0]  op_dst;
    logic [8:0]  op_code;
    logic [15:0] jump_pc;
    logic        rf_re_o, rf_we_o;
    logic [4:0]  rf_raddr_o, rf_waddr_o;
    logic [31:0] rf_rdata, rf_wdata_o;
    logic        rsm_valid = 1'b0, rsm_inc = 1'b0, rsm_step = 1'b0;
    logic [1:0]  rsm_task = '0;
    logic [3:0]  paused_o;

    logic        m_we = 1'b0;
    logic [4:0]  m_addr = '0;
    logic [31:0] m_data = '0;

    logic [31:0] rf [32];
    logic        im_p [4][16];
    logic        im_f [4][16];
    logic [4:0]  im_d [4][16];
    logic [8:0]  im_c [4][16];

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpu_pause_unit u0 (
        .clk(clk), .rst(rst), .slot_o(slot_o), .fetch_pc_o(fetch_pc_o), .pcs_o(pcs_o),
        .op_pause_i(op_pause), .op_flag_i(op_flag), .op_dst_i(op_dst), .op_code_i(op_code),
        .jump_en_i(jump_en), .jump_pc_i(jump_pc),
        .rf_re_o(rf_re_o), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .rsm_valid_i(rsm_valid), .rsm_task_i(rsm_task), .rsm_inc_i(rsm_inc),
        .rsm_step_i(rsm_step), .paused_o(paused_o)
    );

    // instruction fetch from the bench program memory
    always_comb begin
        op_pause = im_p[slot_o][fetch_pc_o[3:0]];
        op_flag  = im_f[slot_o][fetch_pc_o[3:0]];
        op_dst   = im_d[slot_o][fetch_pc_o[3:0]];
        op_code  = im_c[slot_o][fetch_pc_o[3:0]];
        jump_en  = 1'b0;
        jump_pc  = '0;
    end

    // register file: writes on the edge, reads combinational (old value)
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) rf[i] <= '0;
        end else begin
            if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
            if (m_we)    rf[m_addr]     <= m_data;
        end
    end
    assign rf_rdata = rf[rf_raddr_o];

    function automatic logic [15:0] pc_of(input int t);
        return pcs_o[t*16 +: 16];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_slot(input int t);
        while (slot_o != 2'(t)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic align(input int t);
        while (slot_o != 2'(t)) @(negedge clk);
    endtask

    task automatic mwrite(input logic [4:0] a, input logic [31:0] d);
        m_we = 1'b1; m_addr = a; m_data = d;
        @(negedge clk);
        m_we = 1'b0;
    endtask

    task automatic resume(input int t, input logic inc, input logic step);
        rsm_valid = 1'b1; rsm_task = 2'(t); rsm_inc = inc; rsm_step = step;
        @(negedge clk);
        rsm_valid = 1'b0; rsm_inc = 1'b0; rsm_step = 1'b0;
    endtask

    task automatic wait_paused(input int t, input string req);
        int n = 0;
        while (!paused_o[t] && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(req, 32'(paused_o[t]), 32'd1);
    endtask

    task automatic set_pause(input int t, input int pc, input logic f,
                             input logic [4:0] d, input logic [8:0] c);
        im_p[t][pc] = 1'b1; im_f[t][pc] = f; im_d[t][pc] = d; im_c[t][pc] = c;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        for (int t = 0; t < 4; t++)
            for (int p = 0; p < 16; p++) begin
                im_p[t][p] = 1'b0; im_f[t][p] = 1'b0; im_d[t][p] = '0; im_c[t][p] = '0;
            end
        set_pause(0, 2,  1'b0, 5'd1, 9'h1A5);
        set_pause(0, 5,  1'b0, 5'd4, 9'h101);
        set_pause(0, 8,  1'b0, 5'd5, 9'h1FF);
        set_pause(1, 1,  1'b0, 5'd2, 9'h000);
        set_pause(1, 14, 1'b0, 5'd6, 9'h0C3);
        set_pause(2, 1,  1'b1, 5'd3, 9'h0AB);  // selects bit 31
        set_pause(2, 2,  1'b1, 5'd3, 9'h003);  // selects bit 31
        set_pause(3, 1,  1'b1, 5'd3, 9'h0F2);  // selects bit 30
        set_pause(3, 2,  1'b1, 5'd3, 9'h002);

        repeat (3) @(negedge clk);
        chk("R1 reset paused", 32'(paused_o), 32'd0);
        chk("R1 reset pcs", pcs_o[31:0] | pcs_o[63:32], 32'd0);
        chk("R1 reset slot", 32'(slot_o), 32'd0);
        rst = 1'b0;

        // R11: resume aimed at a running task must not arm a step
        resume(1, 1'b1, 1'b1);
        chk("R1 slot after one clock", 32'(slot_o), 32'd1);
        wait_slot(1);
        chk("R1 slot rotation", 32'(slot_o), 32'd2);
        chk("R11 ignored resume pc", 32'(pc_of(1)), 32'd1);
        chk("R11 ignored resume paused", 32'(paused_o[1]), 32'd0);

        mwrite(5'd2, 32'h0000_BEEF);
        mwrite(5'd3, 32'h0123_4000);

        // R2 / R5: code-0 pause on task 1
        wait_slot(1);
        chk("R5 zero code written", rf[2], 32'h0);
        chk("R2 paused on entry", 32'(paused_o[1]), 32'd1);
        chk("R2 pc held on entry", 32'(pc_of(1)), 32'd1);
        wait_slot(1);
        chk("R5 self release", 32'(paused_o[1]), 32'd0);
        chk("R5 pc advanced", 32'(pc_of(1)), 32'd2);

        // R2 / R7: default pause on task 0, flag pauses on tasks 2 and 3
        wait_slot(0);
        chk("R2 code zero-extended", rf[1], 32'h0000_01A5);
        chk("R2 task0 paused", 32'(paused_o[0]), 32'd1);
        wait_slot(3);
        chk("R7 merged flag word", rf[3], 32'hC123_40F2);
        chk("R7 both flag waiters paused", 32'(paused_o[3:2]), 32'd3);

        // R3: spinning leaves no trace
        for (int k = 0; k < 3; k++) begin
            align(0);
            chk("R3 no write in paused slot", 32'(rf_we_o), 32'd0);
            chk("R3 poll address", 32'(rf_raddr_o), 32'd1);
            @(negedge clk);
            chk("R3 pc frozen", 32'(pc_of(0)), 32'd2);
        end

        // R6 then R4: clear on the same edge as the poll
        align(0);
        mwrite(5'd1, 32'h0);
        chk("R6 poll saw old value", 32'(paused_o[0]), 32'd1);
        wait_slot(0);
        chk("R4 released on zero", 32'(paused_o[0]), 32'd0);
        chk("R4 pc after release", 32'(pc_of(0)), 32'd3);

        // R8: clear only bit 31, data bits all ones
        align(0);
        mwrite(5'd3, 32'h4FFF_FFFF);
        wait_slot(2);
        chk("R8 bit31 waiter released", 32'(paused_o[2]), 32'd0);
        chk("R8 bit31 waiter pc", 32'(pc_of(2)), 32'd2);
        wait_slot(3);
        chk("R8 bit30 waiter still paused", 32'(paused_o[3]), 32'd1);
        wait_slot(2);
        chk("R7 second flag word", rf[3], 32'hCFFF_FE03);
        chk("R7 task2 paused again", 32'(paused_o[2]), 32'd1);
        align(0);
        mwrite(5'd3, 32'h0ABC_DEF0);
        wait_slot(2);
        chk("R8 one write frees task2", 32'(paused_o[2]), 32'd0);
        chk("R8 task2 pc", 32'(pc_of(2)), 32'd3);
        wait_slot(3);
        chk("R8 one write frees task3", 32'(paused_o[3]), 32'd0);
        chk("R8 task3 pc", 32'(pc_of(3)), 32'd2);

        // R9: advancing resume
        wait_paused(0, "R9 task0 paused at pc5");
        chk("R9 pause address", 32'(pc_of(0)), 32'd5);
        resume(0, 1'b1, 1'b0);
        chk("R9 inc resume released", 32'(paused_o[0]), 32'd0);
        chk("R9 inc resume pc", 32'(pc_of(0)), 32'd6);

        // R9 no-advance plus R10 single step
        wait_paused(0, "R10 task0 paused at pc8");
        chk("R10 pause address", 32'(pc_of(0)), 32'd8);
        im_p[0][8] = 1'b0;  // original instruction restored
        resume(0, 1'b0, 1'b1);
        chk("R9 no-inc resume released", 32'(paused_o[0]), 32'd0);
        chk("R9 no-inc resume pc", 32'(pc_of(0)), 32'd8);
        wait_slot(0);
        chk("R10 stepped one instruction", 32'(pc_of(0)), 32'd9);
        chk("R10 re-paused after step", 32'(paused_o[0]), 32'd1);
        mwrite(5'd5, 32'h0);
        wait_slot(0);
        wait_slot(0);
        chk("R10 hold ignores register", 32'(paused_o[0]), 32'd1);
        chk("R10 hold pc", 32'(pc_of(0)), 32'd9);
        resume(0, 1'b1, 1'b0);
        chk("R10 second resume pc", 32'(pc_of(0)), 32'd10);
        wait_slot(0);
        chk("R10 runs normally", 32'(pc_of(0)), 32'd11);
        chk("R10 not paused", 32'(paused_o[0]), 32'd0);

        // R12: poll release and resume on the same edge
        wait_paused(1, "R12 task1 paused at pc14");
        chk("R12 pause address", 32'(pc_of(1)), 32'd14);
        align(2);
        mwrite(5'd6, 32'h0);
        align(1);
        resume(1, 1'b1, 1'b0);
        chk("R12 released", 32'(paused_o[1]), 32'd0);
        chk("R12 single increment", 32'(pc_of(1)), 32'd15);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule